// File: doc/BRIEF.md
# Block-Cipher Engine Control Register

This block is the single control word that software uses to configure a block-cipher accelerator. It holds the enable bit, the operating mode, the chaining mode, the key length, the key source, the data-swap selection, the phase of the authenticated modes, the count of padding bytes in the final block, two DMA request enables and a software reset bit. Software reaches it over a simple register bus. The bus has an address, a write strobe, write data and registered read data.

The engine reports its state through a busy input and a key-valid input, and through two completion pulses. While the engine is running, the register refuses configuration changes that would disturb it. It drops the enable bit when the engine signals that key preparation or the initial phase of an authenticated mode has finished. Downstream, it gates the engine's two DMA request lines by mode, drives a soft-reset level and flags reserved encodings. The cipher datapath, the key schedule and the byte swapping itself sit outside the block.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After the synchronous reset, every field, `rdata`, `soft_rst`, `config_error` and `dma_req` are 0.
- R2: The control word sits at address `CTRL_ADDR`. Bit layout: enable [0], op mode [2:1], chaining [5:3], key length [6], key source [9:8], swap [11:10], phase [13:12], padding [19:16], DMA in [20], DMA out [21], soft reset [31]. All other bits read 0. A read shows the word one cycle after the address is presented. Other addresses read 0, and writes to them change nothing.
- R3: While `eng_busy` is 1, a write leaves op mode, chaining, key length, key source and swap unchanged.
- R4: When enable is 1 before a write and the write keeps bit 0 at 1, those same five fields are unchanged. A write that clears enable updates them.
- R5: A write that sets enable while `key_valid` is 0 leaves enable at 0.
- R6: Enable clears on `keyprep_done` while op mode is 1 (key derivation). It also clears on `initph_done` while chaining is 3 (authenticated) and phase is 0 (init). A clear event in the same cycle as a software write that sets enable wins over that write.
- R7: `dma_req[0]` (input side) and `dma_req[1]` (output side) follow `eng_dma_req` one cycle later. This happens only when the matching enable bit is set and op mode is 0 (encrypt) or 2 (decrypt). In op mode 1 both stay 0.
- R8: A write with bit 31 set clears all other fields and holds them at 0, and `soft_rst` stays 1 until a write clears bit 31.
- R9: `auth_phase` equals the stored phase only while chaining is 3. Otherwise it is 0, although readback still shows the stored value.
- R10: `config_error` is 1 while op mode is 3, while chaining is above 3, or while the key source is 1 or 3. Such values are stored as written.
- R11: Phase, padding (0 to 15) and the DMA enables are written regardless of busy or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| eng_busy | input | 1 | Engine busy status |
| key_valid | input | 1 | Key loaded and valid |
| keyprep_done | input | 1 | Key preparation finished pulse |
| initph_done | input | 1 | Authenticated init phase finished pulse |
| eng_dma_req | input | 2 | Raw DMA requests from the engine (0 in, 1 out) |
| dma_req | output | 2 | Gated DMA requests |
| enable | output | 1 | Engine enable |
| op_mode | output | 2 | Operating mode |
| chain_mode | output | 3 | Chaining mode |
| key_long | output | 1 | Long key selected |
| key_mode | output | 2 | Key source |
| swap_sel | output | 2 | Data swap selection |
| auth_phase | output | 2 | Effective authenticated phase |
| pad_bytes | output | 4 | Padding bytes in last block |
| soft_rst | output | 1 | Soft reset level to the engine |
| config_error | output | 1 | Reserved encoding held |

## Verification
A software write that sets enable can land in the same cycle as a hardware completion pulse that clears it. The bench drives the write strobe with set enable and `keyprep_done` together, while op mode is key derivation. It judges the result by sampling `enable` after that edge and expecting 0. A second pair has a protected-field write coincide with the engine's busy level while enable toggles. The bench then expects the enable bit to move and the protected fields to hold.

// File: rtl/cectl_pkg.sv
package cectl_pkg;
  localparam int REG_W     = 32;
  localparam int MODE_W    = 2;
  localparam int CHAIN_W   = 3;
  localparam int KMODE_W   = 2;
  localparam int SWAP_W    = 2;
  localparam int PHASE_W   = 2;
  localparam int PAD_W     = 4;

  localparam int EN_BIT    = 0;
  localparam int MODE_LSB  = 1;
  localparam int CHAIN_LSB = 3;
  localparam int KLEN_BIT  = 6;
  localparam int KMODE_LSB = 8;
  localparam int SWAP_LSB  = 10;
  localparam int PHASE_LSB = 12;
  localparam int PAD_LSB   = 16;
  localparam int DIN_BIT   = 20;
  localparam int DOUT_BIT  = 21;
  localparam int SRST_BIT  = 31;

  localparam logic [MODE_W-1:0]  OP_ENCRYPT  = 2'd0;
  localparam logic [MODE_W-1:0]  OP_KEYDERIV = 2'd1;
  localparam logic [MODE_W-1:0]  OP_DECRYPT  = 2'd2;
  localparam logic [MODE_W-1:0]  OP_RSVD     = 2'd3;
  localparam logic [CHAIN_W-1:0] CH_AUTH     = 3'd3;
  localparam logic [KMODE_W-1:0] KM_RSVD_A   = 2'd1;
  localparam logic [KMODE_W-1:0] KM_RSVD_B   = 2'd3;
  localparam logic [PHASE_W-1:0] PH_INIT     = 2'd0;

  typedef struct packed {
    logic               dma_out;
    logic               dma_in;
    logic [PAD_W-1:0]   pad;
    logic [PHASE_W-1:0] phase;
    logic [SWAP_W-1:0]  swap;
    logic [KMODE_W-1:0] kmode;
    logic               klong;
    logic [CHAIN_W-1:0] chain;
    logic [MODE_W-1:0]  mode;
  } cfg_t;

  function automatic logic [REG_W-1:0] pack_word(cfg_t c, logic en, logic srst);
    logic [REG_W-1:0] w;
    w = '0;
    w[EN_BIT]                       = en;
    w[MODE_LSB  +: MODE_W]          = c.mode;
    w[CHAIN_LSB +: CHAIN_W]         = c.chain;
    w[KLEN_BIT]                     = c.klong;
    w[KMODE_LSB +: KMODE_W]         = c.kmode;
    w[SWAP_LSB  +: SWAP_W]          = c.swap;
    w[PHASE_LSB +: PHASE_W]         = c.phase;
    w[PAD_LSB   +: PAD_W]           = c.pad;
    w[DIN_BIT]                      = c.dma_in;
    w[DOUT_BIT]                     = c.dma_out;
    w[SRST_BIT]                     = srst;
    return w;
  endfunction

  function automatic cfg_t unpack_word(logic [REG_W-1:0] w);
    cfg_t c;
    c.mode    = w[MODE_LSB  +: MODE_W];
    c.chain   = w[CHAIN_LSB +: CHAIN_W];
    c.klong   = w[KLEN_BIT];
    c.kmode   = w[KMODE_LSB +: KMODE_W];
    c.swap    = w[SWAP_LSB  +: SWAP_W];
    c.phase   = w[PHASE_LSB +: PHASE_W];
    c.pad     = w[PAD_LSB   +: PAD_W];
    c.dma_in  = w[DIN_BIT];
    c.dma_out = w[DOUT_BIT];
    return c;
  endfunction
endpackage

// File: rtl/cectl_field_guard.sv
module cectl_field_guard
  import cectl_pkg::*;
(
  input  logic wr_hit,
  input  logic wr_en_bit,
  input  cfg_t wr_cfg,
  input  logic eng_busy,
  input  logic en_q,
  input  cfg_t cfg_q,
  output cfg_t cfg_d
);
  logic locked;

  // Protected fields freeze while busy, or while enable stays set across the write.
  assign locked = eng_busy | (en_q & wr_en_bit);

  always_comb begin
    cfg_d = cfg_q;
    if (wr_hit) begin
      cfg_d.phase   = wr_cfg.phase;
      cfg_d.pad     = wr_cfg.pad;
      cfg_d.dma_in  = wr_cfg.dma_in;
      cfg_d.dma_out = wr_cfg.dma_out;
      if (!locked) begin
        cfg_d.mode  = wr_cfg.mode;
        cfg_d.chain = wr_cfg.chain;
        cfg_d.klong = wr_cfg.klong;
        cfg_d.kmode = wr_cfg.kmode;
        cfg_d.swap  = wr_cfg.swap;
      end
    end
  end
endmodule

// File: rtl/cectl_enable_ctl.sv
module cectl_enable_ctl
  import cectl_pkg::*;
(
  input  logic               wr_hit,
  input  logic               wr_en_bit,
  input  logic               key_valid,
  input  logic               keyprep_done,
  input  logic               initph_done,
  input  logic [MODE_W-1:0]  mode,
  input  logic [CHAIN_W-1:0] chain,
  input  logic [PHASE_W-1:0] phase,
  input  logic               en_q,
  output logic               en_d
);
  logic hw_clear;

  assign hw_clear = (keyprep_done && mode == OP_KEYDERIV) ||
                    (initph_done && chain == CH_AUTH && phase == PH_INIT);

  always_comb begin
    en_d = en_q;
    if (wr_hit) en_d = wr_en_bit ? (en_q | key_valid) : 1'b0;
    if (hw_clear) en_d = 1'b0;
  end
endmodule

// File: rtl/cectl_dma_gate.sv
module cectl_dma_gate
  import cectl_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] eng_req,
  output logic [NUM_CH-1:0] req_out
);
  logic mode_ok;

  assign mode_ok = (mode == OP_ENCRYPT) || (mode == OP_DECRYPT);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) req_out[i] <= 1'b0;
      else     req_out[i] <= eng_req[i] & chan_en[i] & mode_ok;
    end
  end
endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
  import cectl_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  input  logic                eng_busy,
  input  logic                key_valid,
  input  logic                keyprep_done,
  input  logic                initph_done,
  input  logic [1:0]          eng_dma_req,
  output logic [1:0]          dma_req,
  output logic                enable,
  output logic [MODE_W-1:0]   op_mode,
  output logic [CHAIN_W-1:0]  chain_mode,
  output logic                key_long,
  output logic [KMODE_W-1:0]  key_mode,
  output logic [SWAP_W-1:0]   swap_sel,
  output logic [PHASE_W-1:0]  auth_phase,
  output logic [PAD_W-1:0]    pad_bytes,
  output logic                soft_rst,
  output logic                config_error
);
  localparam int DMA_CH = 2;

  cfg_t cfg_q, cfg_d, wr_cfg;
  logic en_q, en_d, srst_q, srst_d, wr_hit, sel_hit;
  logic [REG_W-1:0] rdata_q;

  assign sel_hit = (addr == CTRL_ADDR);
  assign wr_hit  = wr_en & sel_hit;
  assign wr_cfg  = unpack_word(wdata);
  assign srst_d  = wr_hit ? wdata[SRST_BIT] : srst_q;

  cectl_field_guard u_guard (
    .wr_hit    (wr_hit),
    .wr_en_bit (wdata[EN_BIT]),
    .wr_cfg    (wr_cfg),
    .eng_busy  (eng_busy),
    .en_q      (en_q),
    .cfg_q     (cfg_q),
    .cfg_d     (cfg_d)
  );

  cectl_enable_ctl u_en (
    .wr_hit       (wr_hit),
    .wr_en_bit    (wdata[EN_BIT]),
    .key_valid    (key_valid),
    .keyprep_done (keyprep_done),
    .initph_done  (initph_done),
    .mode         (cfg_q.mode),
    .chain        (cfg_q.chain),
    .phase        (cfg_q.phase),
    .en_q         (en_q),
    .en_d         (en_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      srst_q <= 1'b0;
    end else if (srst_d) begin
      cfg_q  <= '0;
      en_q   <= 1'b0;
      srst_q <= 1'b1;
    end else begin
      cfg_q  <= cfg_d;
      en_q   <= en_d;
      srst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (sel_hit) rdata_q <= pack_word(cfg_q, en_q, srst_q);
    else              rdata_q <= '0;
  end

  cectl_dma_gate #(.NUM_CH(DMA_CH)) u_dma (
    .clk     (clk),
    .rst     (rst),
    .mode    (cfg_q.mode),
    .chan_en ({cfg_q.dma_out, cfg_q.dma_in}),
    .eng_req (eng_dma_req),
    .req_out (dma_req)
  );

  assign rdata        = rdata_q;
  assign enable       = en_q;
  assign op_mode      = cfg_q.mode;
  assign chain_mode   = cfg_q.chain;
  assign key_long     = cfg_q.klong;
  assign key_mode     = cfg_q.kmode;
  assign swap_sel     = cfg_q.swap;
  assign pad_bytes    = cfg_q.pad;
  assign soft_rst     = srst_q;
  assign auth_phase   = (cfg_q.chain == CH_AUTH) ? cfg_q.phase : '0;
  assign config_error = (cfg_q.mode == OP_RSVD) || (cfg_q.chain > CH_AUTH) ||
                        (cfg_q.kmode == KM_RSVD_A) || (cfg_q.kmode == KM_RSVD_B);
endmodule

// File: rtl/cectl_regs_chk.sv
module cectl_regs_chk
  import cectl_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [REG_W-1:0]   wdata,
  input logic               eng_busy,
  input logic               key_valid,
  input logic               keyprep_done,
  input logic               enable,
  input logic [MODE_W-1:0]  op_mode,
  input logic [CHAIN_W-1:0] chain_mode,
  input logic               key_long,
  input logic [KMODE_W-1:0] key_mode,
  input logic [SWAP_W-1:0]  swap_sel,
  input logic [PAD_W-1:0]   pad_bytes,
  input logic [1:0]         dma_req,
  input logic               soft_rst,
  input logic               config_error
);
  assert_busy_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR && eng_busy && !wdata[SRST_BIT]) |=>
      ($stable(op_mode) && $stable(chain_mode) && $stable(key_long) &&
       $stable(key_mode) && $stable(swap_sel)));

  assert_enable_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_ADDR && enable && wdata[EN_BIT] && !wdata[SRST_BIT]) |=>
      ($stable(op_mode) && $stable(chain_mode) && $stable(key_long) &&
       $stable(key_mode) && $stable(swap_sel)));

  assert_no_set_without_key_R5: assert property (@(posedge clk) disable iff (rst)
    (!enable && !key_valid) |=> !enable);

  assert_keyprep_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (keyprep_done && op_mode == OP_KEYDERIV) |=> !enable);

  assert_keyderiv_no_dma_R7: assert property (@(posedge clk) disable iff (rst)
    (op_mode == OP_KEYDERIV) |=> (dma_req == 2'b00));

  assert_soft_reset_zero_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> (!enable && op_mode == '0 && chain_mode == '0 && pad_bytes == '0 &&
                  key_mode == '0 && swap_sel == '0 && !key_long));

  assert_err_from_write_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(config_error) |-> $past(wr_en));
endmodule

bind cipher_ctl_regs cectl_regs_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .eng_busy(eng_busy), .key_valid(key_valid), .keyprep_done(keyprep_done),
  .enable(enable), .op_mode(op_mode), .chain_mode(chain_mode), .key_long(key_long),
  .key_mode(key_mode), .swap_sel(swap_sel), .pad_bytes(pad_bytes), .dma_req(dma_req),
  .soft_rst(soft_rst), .config_error(config_error)
);

// File: tb/cipher_ctl_regs_test.sv
module cipher_ctl_regs_test;
  localparam int AW = 4;
  localparam logic [AW-1:0] CTRL = 4'd0;
  localparam int NV = 8;
  // {busy, key_valid, wdata, expected readback}
  localparam logic [65:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'h7FFF_FFFF, 32'h003F_3F7E},  // R5 set blocked, R2 reserved bits 0
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b0, 1'b1, 32'h0000_1A45, 32'h0000_1A45},  // enable with key valid
    {1'b0, 1'b1, 32'h0000_001B, 32'h0000_0A45},  // R4 held enable freezes fields
    {1'b0, 1'b1, 32'h0000_001A, 32'h0000_001A},  // R4 clearing write updates
    {1'b1, 1'b1, 32'h0000_0007, 32'h0000_001B},  // R3 busy freezes, enable still sets
    {1'b1, 1'b1, 32'h0030_5000, 32'h0030_101A},  // R3 and R11 unprotected fields move
    {1'b0, 1'b1, 32'h000F_0004, 32'h000F_0004}   // R11 pad 15
  };

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic eng_busy = 1'b0, key_valid = 1'b0, keyprep_done = 1'b0, initph_done = 1'b0;
  logic [1:0] eng_dma_req = 2'b00, dma_req;
  logic enable, key_long, soft_rst, config_error;
  logic [1:0] op_mode, key_mode, swap_sel, auth_phase;
  logic [2:0] chain_mode;
  logic [3:0] pad_bytes;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cipher_ctl_regs #(.ADDR_W(AW), .CTRL_ADDR(CTRL)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .eng_busy(eng_busy), .key_valid(key_valid), .keyprep_done(keyprep_done),
    .initph_done(initph_done), .eng_dma_req(eng_dma_req), .dma_req(dma_req),
    .enable(enable), .op_mode(op_mode), .chain_mode(chain_mode), .key_long(key_long),
    .key_mode(key_mode), .swap_sel(swap_sel), .auth_phase(auth_phase),
    .pad_bytes(pad_bytes), .soft_rst(soft_rst), .config_error(config_error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic b, input logic kv);
    @(negedge clk);
    addr = a; wdata = d; eng_busy = b; key_valid = kv; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; eng_busy = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic pulse(input logic kp, input logic ip);
    @(negedge clk);
    keyprep_done = kp; initph_done = ip;
    @(posedge clk); #1;
    keyprep_done = 1'b0; initph_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    rd(CTRL);
    check("R1 rdata", rdata, 32'h0);
    check("R1 outputs", {26'h0, enable, soft_rst, config_error, dma_req, |pad_bytes}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(CTRL, VECS[i][63:32], VECS[i][65], VECS[i][64]);
      rd(CTRL);
      check($sformatf("R2 R3 R4 R5 R11 vector %0d", i), rdata, VECS[i][31:0]);
    end

    // R2 other address: no write effect, reads 0
    wr(4'd1, 32'h7FFF_FFFF, 1'b0, 1'b1);
    rd(4'd1);
    check("R2 other addr read", rdata, 32'h0);
    rd(CTRL);
    check("R2 other addr write ignored", rdata, 32'h000F_0004);

    // R5 direct
    wr(CTRL, 32'h0000_0001, 1'b0, 1'b0);
    check("R5 enable blocked", {31'h0, enable}, 32'h0);

    // R6 hardware clear vs software set in one cycle
    wr(CTRL, 32'h0000_0002, 1'b0, 1'b1);
    @(negedge clk);
    addr = CTRL; wdata = 32'h0000_0003; wr_en = 1'b1; keyprep_done = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0; keyprep_done = 1'b0;
    check("R6 clear beats set", {31'h0, enable}, 32'h0);
    wr(CTRL, 32'h0000_0003, 1'b0, 1'b1);
    check("R6 set ok", {31'h0, enable}, 32'h1);
    pulse(1'b1, 1'b0);
    check("R6 keyprep clear", {31'h0, enable}, 32'h0);
    wr(CTRL, 32'h0000_0019, 1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    check("R6 init phase clear", {31'h0, enable}, 32'h0);
    wr(CTRL, 32'h0000_1019, 1'b0, 1'b1);
    pulse(1'b0, 1'b1);
    check("R6 no clear in header phase", {31'h0, enable}, 32'h1);
    wr(CTRL, 32'h0000_0000, 1'b0, 1'b1);

    // R7 DMA gating
    eng_dma_req = 2'b11;
    wr(CTRL, 32'h0030_0000, 1'b0, 1'b1); rd(CTRL);
    check("R7 encrypt both", {30'h0, dma_req}, 32'h3);
    wr(CTRL, 32'h0030_0002, 1'b0, 1'b1); rd(CTRL);
    check("R7 keyderiv blocked", {30'h0, dma_req}, 32'h0);
    wr(CTRL, 32'h0030_0004, 1'b0, 1'b1); rd(CTRL);
    check("R7 decrypt both", {30'h0, dma_req}, 32'h3);
    wr(CTRL, 32'h0010_0004, 1'b0, 1'b1); rd(CTRL);
    check("R7 input only", {30'h0, dma_req}, 32'h1);
    eng_dma_req = 2'b00;

    // R8 soft reset
    wr(CTRL, 32'h0030_0045, 1'b0, 1'b1);
    wr(CTRL, 32'h8000_FFFF, 1'b0, 1'b1);
    check("R8 soft_rst high", {31'h0, soft_rst}, 32'h1);
    rd(CTRL);
    check("R8 fields cleared", rdata, 32'h8000_0000);
    wr(CTRL, 32'h0000_0000, 1'b0, 1'b1);
    check("R8 soft_rst released", {31'h0, soft_rst}, 32'h0);

    // R10 reserved encodings
    wr(CTRL, 32'h0000_0006, 1'b0, 1'b1);
    check("R10 mode 3", {31'h0, config_error}, 32'h1);
    rd(CTRL);
    check("R10 stored as written", rdata, 32'h0000_0006);
    wr(CTRL, 32'h0000_0020, 1'b0, 1'b1);
    check("R10 chain 4", {31'h0, config_error}, 32'h1);
    wr(CTRL, 32'h0000_0100, 1'b0, 1'b1);
    check("R10 key source 1", {31'h0, config_error}, 32'h1);
    wr(CTRL, 32'h0000_0200, 1'b0, 1'b1);
    check("R10 key source 2 valid", {31'h0, config_error}, 32'h0);

    // R9 phase visibility
    wr(CTRL, 32'h0000_3000, 1'b0, 1'b1);
    check("R9 phase hidden", {30'h0, auth_phase}, 32'h0);
    rd(CTRL);
    check("R9 phase stored", rdata, 32'h0000_3000);
    wr(CTRL, 32'h0000_3018, 1'b0, 1'b1);
    check("R9 phase shown", {30'h0, auth_phase}, 32'h3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule